// File: doc/BRIEF.md
# Two-Stage Lockable Watchdog Timer

This block is a watchdog peripheral reached through a plain 32-bit register port. Software loads a period value and sets the enable bit. A down-counter then runs one step on each cycle where the tick-enable input is high. When the counter runs out for the first time, an interrupt is raised and the period is reloaded. If software does not clear the interrupt before the counter runs out again, the block asserts a system reset request, provided that reset generation is enabled. The full timeout is therefore two periods. Software services the watchdog by writing to the clear register, which drops the interrupt and restarts the period.

Stray writes are kept away from the timer by a lock register. Only one magic value opens it, and any other value closes it again. While the block is locked, writes to every other register are dropped. Reads are combinational on the address and are always allowed. The block comes out of bus reset locked and stopped, with the load value at all ones.

Top module: `wdog_twostage`

## Requirements
- R1: After bus reset the lock register (0xC00) reads 1, the control register reads 0, the load and count registers read 0xFFFFFFFF, the raw status reads 0, and irq and sys_rst are low.
- R2: Writing 0x1ACCE551 to 0xC00 unlocks the block, so that bit 0 of 0xC00 reads 0. Writing any other value to 0xC00 locks it, so that bit 0 reads 1. Writes to 0xC00 are accepted whether the block is locked or not.
- R3: While the block is locked, writes to the load (0x000), control (0x008) and clear (0x00C) registers have no effect.
- R4: In the control register (0x008), bit 0 enables the counter and the interrupt, and bit 1 enables the reset request. Bits 31:2 read as zero. A write that has bit 0 set reloads the counter from the load register.
- R5: While enabled, the counter at 0x004 decreases by one on every cycle where tick is high. It holds its value when tick is low or when the block is disabled. Writes to 0x004 have no effect.
- R6: A tick while the counter is 0 is an expiry, so with load N the first expiry comes on tick N+1. An expiry reloads the counter from the load value and sets the raw status at 0x010, bit 0.
- R7: An expiry that occurs while the raw status is already set and reset is enabled asserts sys_rst. Once asserted, sys_rst stays high until bus reset.
- R8: When reset is not enabled, a second expiry leaves sys_rst low, keeps the raw status set and reloads the counter.
- R9: A write of any value to 0x00C clears the raw status and reloads the counter from the load value.
- R10: The masked status at 0x014 (bit 0) and the irq pin equal the raw status ANDed with the enable bit. Clearing the enable bit stops the counter and leaves the raw status unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low bus reset |
| tick | input | 1 | Count enable; one counter step per high cycle |
| reg_wr | input | 1 | Write strobe for reg_addr / reg_wdata |
| reg_addr | input | 12 | Register byte address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| irq | output | 1 | Masked interrupt |
| sys_rst | output | 1 | System reset request, sticky |

## Verification
On every cycle, the in-line assertions check the following. The counter steps down by exactly one per enabled tick and holds when there is neither a tick nor a write. Writes made while the block is locked leave the configuration unchanged. The reset request is sticky, and it rises only from an expiry that finds the interrupt pending with reset enabled. A write to the clear register drops the interrupt and reloads the counter. Only the bench's scenarios can show the rest: the exact expiry cycle after N+1 ticks, the difference between the two-period timeout with reset enabled and the same timeout with reset disabled, the interrupt being held while the timer is disabled, and the lock key opening and closing the block.

// File: rtl/wdog_twostage.sv
module wdog_twostage #(
  parameter int              DW        = 32,
  parameter int              AW        = 12,
  parameter logic [DW-1:0]   KEY       = 32'h1ACCE551,
  parameter logic [DW-1:0]   LOAD_INIT = '1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          reg_wr,
  input  logic [AW-1:0] reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          irq,
  output logic          sys_rst
);
  localparam logic [AW-1:0] A_LOAD = AW'('h000);
  localparam logic [AW-1:0] A_CNT  = AW'('h004);
  localparam logic [AW-1:0] A_CTRL = AW'('h008);
  localparam logic [AW-1:0] A_ICLR = AW'('h00C);
  localparam logic [AW-1:0] A_RAW  = AW'('h010);
  localparam logic [AW-1:0] A_MSK  = AW'('h014);
  localparam logic [AW-1:0] A_LOCK = AW'('hC00);

  logic          locked, en_q, rsten_q, raw_q, sysrst_q;
  logic [DW-1:0] load_q, cnt_q;

  wire wr_open  = reg_wr & ~locked;
  wire hit_load = wr_open && reg_addr == A_LOAD;
  wire hit_ctrl = wr_open && reg_addr == A_CTRL;
  wire hit_iclr = wr_open && reg_addr == A_ICLR;
  wire reload   = (hit_ctrl & reg_wdata[0]) | hit_iclr;
  wire step     = en_q & tick & ~reload;
  wire expire   = step && cnt_q == '0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                              locked <= 1'b1;
    else if (reg_wr && reg_addr == A_LOCK)   locked <= (reg_wdata != KEY);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)        load_q <= LOAD_INIT;
    else if (hit_load) load_q <= reg_wdata;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      en_q    <= 1'b0;
      rsten_q <= 1'b0;
    end else if (hit_ctrl) begin
      en_q    <= reg_wdata[0];
      rsten_q <= reg_wdata[1];
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      cnt_q <= LOAD_INIT;
    else if (reload) cnt_q <= load_q;
    else if (expire) cnt_q <= load_q;
    else if (step)   cnt_q <= cnt_q - 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)        raw_q <= 1'b0;
    else if (hit_iclr) raw_q <= 1'b0;
    else if (expire)   raw_q <= 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                           sysrst_q <= 1'b0;
    else if (expire && raw_q && rsten_q)  sysrst_q <= 1'b1;

  assign irq     = raw_q & en_q;
  assign sys_rst = sysrst_q;

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_LOAD: reg_rdata = load_q;
      A_CNT:  reg_rdata = cnt_q;
      A_CTRL: reg_rdata = {{(DW-2){1'b0}}, rsten_q, en_q};
      A_RAW:  reg_rdata = {{(DW-1){1'b0}}, raw_q};
      A_MSK:  reg_rdata = {{(DW-1){1'b0}}, raw_q & en_q};
      A_LOCK: reg_rdata = {{(DW-1){1'b0}}, locked};
      default: reg_rdata = '0;
    endcase
  end

  assert_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst |=> sys_rst);

  assert_rst_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sys_rst) |-> $past(raw_q && rsten_q && en_q && tick));

  assert_locked_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && locked) |=> $stable(load_q) && $stable(en_q) && $stable(rsten_q));

  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !reg_wr) |=> $stable(cnt_q));

  assert_dec_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && tick && !reg_wr && cnt_q != '0) |=> cnt_q == $past(cnt_q) - 1'b1);

  assert_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    hit_iclr |=> !raw_q && cnt_q == $past(load_q));
endmodule

// File: tb/test_wdog_twostage.sv
module test_wdog_twostage;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        reg_wr = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq, sys_rst;

  wdog_twostage i_wdog_twostage (
    .clk(clk), .rst_n(rst_n), .tick(tick), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq(irq), .sys_rst(sys_rst)
  );

  always #4 clk = ~clk;

  typedef struct {
    int          src;
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t q[$];
  logic  chk_req = 1'b0;
  int    total = 0;
  int    bad = 0;
  int    cycles = 0;

  always @(negedge clk) begin
    if (chk_req && q.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it = q.pop_front();
      act = (it.src == 0) ? reg_rdata : (it.src == 1) ? {31'b0, irq} : {31'b0, sys_rst};
      total++;
      if (act !== it.exp) begin
        bad++;
        $display("FAIL %s src=%0d addr=%h actual=%h expected=%h", it.tag, it.src, reg_addr, act, it.exp);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input int src, input logic [11:0] a, input logic [31:0] e, input string tag);
    item_t it;
    @(posedge clk); #1;
    reg_addr = a;
    it.src = src; it.exp = e; it.tag = tag;
    q.push_back(it);
    chk_req = 1'b1;
    @(posedge clk); #1;
    chk_req = 1'b0;
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_wr = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      tick = 1'b1;
    end
    @(posedge clk); #1;
    tick = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    chk(0, 12'hC00, 32'h1, "R1");
    chk(0, 12'h008, 32'h0, "R1");
    chk(0, 12'h000, 32'hFFFF_FFFF, "R1");
    chk(0, 12'h004, 32'hFFFF_FFFF, "R1");
    chk(0, 12'h010, 32'h0, "R1");
    chk(1, 12'h000, 32'h0, "R1");
    chk(2, 12'h000, 32'h0, "R1");

    // R3 writes ignored while locked
    wr(12'h000, 32'd5);
    chk(0, 12'h000, 32'hFFFF_FFFF, "R3");
    wr(12'h008, 32'h3);
    chk(0, 12'h008, 32'h0, "R3");

    // R2 unlock with key
    wr(12'hC00, 32'h1ACCE551);
    chk(0, 12'hC00, 32'h0, "R2");
    wr(12'h000, 32'd5);
    chk(0, 12'h000, 32'd5, "R2");

    // R4 control bits, upper zero, enable reloads counter
    wr(12'h008, 32'hFFFF_FFFD);
    chk(0, 12'h008, 32'h1, "R4");
    chk(0, 12'h004, 32'd5, "R4");

    // R5 decrement, hold, count not writable
    ticks(3);
    chk(0, 12'h004, 32'd2, "R5");
    chk(0, 12'h004, 32'd2, "R5");
    wr(12'h004, 32'd9);
    chk(0, 12'h004, 32'd2, "R5");

    // R6 first expiry on tick N+1
    ticks(2);
    chk(0, 12'h004, 32'd0, "R6");
    chk(0, 12'h010, 32'h0, "R6");
    ticks(1);
    chk(0, 12'h004, 32'd5, "R6");
    chk(0, 12'h010, 32'h1, "R6");
    chk(0, 12'h014, 32'h1, "R10");
    chk(1, 12'h000, 32'h1, "R10");

    // R8 second expiry without reset enable
    ticks(6);
    chk(2, 12'h000, 32'h0, "R8");
    chk(0, 12'h010, 32'h1, "R8");
    chk(0, 12'h004, 32'd5, "R8");

    // R10 disable masks irq, holds raw, stops counter
    wr(12'h008, 32'h0);
    chk(0, 12'h014, 32'h0, "R10");
    chk(1, 12'h000, 32'h0, "R10");
    chk(0, 12'h010, 32'h1, "R10");
    ticks(3);
    chk(0, 12'h004, 32'd5, "R10");

    // R9 clear reloads and drops raw
    wr(12'h008, 32'h1);
    ticks(2);
    chk(0, 12'h004, 32'd3, "R9");
    wr(12'h00C, 32'hDEAD_BEEF);
    chk(0, 12'h010, 32'h0, "R9");
    chk(0, 12'h004, 32'd5, "R9");

    // R7 two periods with reset enabled
    wr(12'h008, 32'h3);
    ticks(6);
    chk(0, 12'h010, 32'h1, "R7");
    chk(2, 12'h000, 32'h0, "R7");
    ticks(6);
    chk(2, 12'h000, 32'h1, "R7");

    // R2 relock with other value, R3 clear ignored while locked
    wr(12'hC00, 32'h0);
    chk(0, 12'hC00, 32'h1, "R2");
    wr(12'h00C, 32'h1);
    chk(0, 12'h010, 32'h1, "R3");

    // R7 sticky after service
    wr(12'hC00, 32'h1ACCE551);
    wr(12'h00C, 32'h1);
    wr(12'h008, 32'h0);
    chk(0, 12'h010, 32'h0, "R9");
    chk(2, 12'h000, 32'h1, "R7");

    // R1 bus reset clears reset request
    @(posedge clk); #1 rst_n = 1'b0;
    @(posedge clk); #1 rst_n = 1'b1;
    chk(2, 12'h000, 32'h0, "R1");
    chk(0, 12'hC00, 32'h1, "R1");

    repeat (2) @(posedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule